// File: doc/BRIEF.md
# Interrupt Cause and Enable Controller

This block keeps the pending interrupt causes and the per-cause enables of a network controller, and drives one interrupt request line from them. Three hardware event pulses feed it: receive done, transmit done and link status change. Each pulse sets its own cause bit. Software uses a word-wide register port to inspect and change the state. It can read the cause vector, inject causes, set and clear enables through two separate registers, and choose which causes a read of the cause register clears.

The request line is registered. It follows the AND of causes and enables one clock later. Reading the cause register returns the whole vector in the same cycle. At the next clock edge the read clears either the bits selected by the auto-clear register, or every bit when that register holds zero. An event that arrives in the same cycle as a clearing read keeps its bit set.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, all registers read zero and `irq_o` is low.
- R2: A one-cycle pulse on `ev_rx_i`, `ev_tx_i` or `ev_link_i` sets cause bit 0, bit 1 or bit 20 respectively.
- R3: A write to word address 0x202 (cause set) sets every written defined cause bit, exactly as the matching event would.
- R4: A write to word address 0x220 sets the written defined enable bits. A read at 0x220 returns the current enable vector.
- R5: A write to word address 0x222 clears every enable bit written as 1 and leaves the other enable bits unchanged.
- R6: `irq_o` is high in the cycle after the cause vector ANDed with the enable vector is nonzero. It goes low one cycle after that AND becomes zero. A cause whose enable bit is clear never raises it.
- R7: A read at word address 0x200 returns the full cause vector. At that clock edge it clears the causes selected by the auto-clear register (word address 0x204, readable), or all causes when that register is zero.
- R8: An event or cause-set write in the same cycle as a clearing cause read leaves that bit set.
- R9: Only bits 0, 1 and 20 can be written or stored in any register. Every other bit reads zero, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_i | input | 1 | Receive-done event pulse |
| ev_tx_i | input | 1 | Transmit-done event pulse |
| ev_link_i | input | 1 | Link status change event pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (cause read has side effect) |
| addr_i | input | 14 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational in the read cycle |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a read strobe lasts exactly one cycle per intended read, because each cycle of a held strobe clears the cause register again. They also assume that event inputs are single-cycle pulses that are low during reset. The stimulus drives every strobe and pulse for exactly one clock, changing them only on the falling edge. Reads and writes never share a cycle, and there is one intentional exception: an event is driven in the same cycle as a cause read to exercise the collision rule.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CAUSE,
      SEL_CSET,
      SEL_ACLR,
      SEL_MSET,
      SEL_MCLR
   } irq_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 14,
   parameter int unsigned OFF_CAUSE = 'h200,
   parameter int unsigned OFF_CSET  = 'h202,
   parameter int unsigned OFF_ACLR  = 'h204,
   parameter int unsigned OFF_MSET  = 'h220,
   parameter int unsigned OFF_MCLR  = 'h222
) (
   input  logic [ADDR_W-1:0] addr_i,
   output irq_sel_e          sel_o
);
   initial begin
      assert (OFF_CAUSE < (2 ** ADDR_W) && OFF_MCLR < (2 ** ADDR_W))
         else $error("register offset does not fit ADDR_W");
      assert (OFF_CAUSE != OFF_CSET && OFF_CSET != OFF_ACLR && OFF_ACLR != OFF_MSET
              && OFF_MSET != OFF_MCLR && OFF_CAUSE != OFF_MSET)
         else $error("register offsets collide");
   end

   always_comb begin
      sel_o = SEL_NONE;
      if      (addr_i == ADDR_W'(OFF_CAUSE)) sel_o = SEL_CAUSE;
      else if (addr_i == ADDR_W'(OFF_CSET))  sel_o = SEL_CSET;
      else if (addr_i == ADDR_W'(OFF_ACLR))  sel_o = SEL_ACLR;
      else if (addr_i == ADDR_W'(OFF_MSET))  sel_o = SEL_MSET;
      else if (addr_i == ADDR_W'(OFF_MCLR))  sel_o = SEL_MCLR;
   end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
   parameter int unsigned       DATA_W = 32,
   parameter logic [DATA_W-1:0] VALID  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_i,
   input  logic              rd_clr_i,
   input  logic [DATA_W-1:0] aclr_i,
   output logic [DATA_W-1:0] cause_o
);
   logic [DATA_W-1:0] set_eff;
   logic [DATA_W-1:0] clr_vec;

   assign set_eff = set_i & VALID;
   assign clr_vec = rd_clr_i ? ((aclr_i == '0) ? '1 : aclr_i) : '0;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (VALID[b]) begin : g_store
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_eff[b]) bit_q <= 1'b1;
            else if (clr_vec[b]) bit_q <= 1'b0;
         end
         assign cause_o[b] = bit_q;
      end else begin : g_tie
         assign cause_o[b] = 1'b0;
      end
   end

   // R2 R3 R8
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_eff) |=> ((cause_o & $past(set_eff)) == $past(set_eff)));

   // R7
   read_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && !(|set_eff) && aclr_i == '0) |=> (cause_o == '0));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int unsigned       DATA_W = 32,
   parameter logic [DATA_W-1:0] VALID  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we_i,
   input  logic              clr_we_i,
   input  logic              load_we_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   logic [DATA_W-1:0] d_eff;
   logic [DATA_W-1:0] q;

   assign d_eff = d_i & VALID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (load_we_i) q <= d_eff;
      else if (set_we_i)  q <= q | d_eff;
      else if (clr_we_i)  q <= q & ~d_eff;
   end

   assign q_o = q;

   // R4
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we_i && !load_we_i) |=> ((q_o & $past(d_eff)) == $past(d_eff)));

   // R5
   clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && !set_we_i && !load_we_i) |=> ((q_o & $past(d_eff)) == '0));

   // R5
   clr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && !set_we_i && !load_we_i)
         |=> ((q_o & ~$past(d_eff)) == ($past(q_o) & ~$past(d_eff))));
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cause_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              irq_o
);
   logic pend;
   assign pend = |(cause_i & mask_i);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq_o = irq_q;

      // R6
      irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pend |=> irq_o);
      // R6
      irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pend |=> !irq_o);
   end else begin : g_comb
      assign irq_o = pend;
   end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 14,
   parameter int unsigned RX_BIT    = 0,
   parameter int unsigned TX_BIT    = 1,
   parameter int unsigned LSC_BIT   = 20,
   parameter int unsigned OFF_CAUSE = 'h200,
   parameter int unsigned OFF_CSET  = 'h202,
   parameter int unsigned OFF_ACLR  = 'h204,
   parameter int unsigned OFF_MSET  = 'h220,
   parameter int unsigned OFF_MCLR  = 'h222,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_rx_i,
   input  logic              ev_tx_i,
   input  logic              ev_link_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] ONE   = DATA_W'(1);
   localparam logic [DATA_W-1:0] VALID = (ONE << RX_BIT) | (ONE << TX_BIT) | (ONE << LSC_BIT);

   initial begin
      assert (RX_BIT < DATA_W && TX_BIT < DATA_W && LSC_BIT < DATA_W)
         else $error("event bit beyond DATA_W");
      assert (RX_BIT != TX_BIT && TX_BIT != LSC_BIT && RX_BIT != LSC_BIT)
         else $error("event bits must be distinct");
   end

   irq_sel_e          sel;
   logic [DATA_W-1:0] cause, mask, aclr;
   logic [DATA_W-1:0] ev_vec, set_vec;
   logic              cause_rd;

   irq_addr_dec #(
      .ADDR_W(ADDR_W), .OFF_CAUSE(OFF_CAUSE), .OFF_CSET(OFF_CSET),
      .OFF_ACLR(OFF_ACLR), .OFF_MSET(OFF_MSET), .OFF_MCLR(OFF_MCLR)
   ) dec_i (
      .addr_i(addr_i),
      .sel_o (sel)
   );

   always_comb begin
      ev_vec = '0;
      ev_vec[RX_BIT]  = ev_rx_i;
      ev_vec[TX_BIT]  = ev_tx_i;
      ev_vec[LSC_BIT] = ev_link_i;
   end

   assign set_vec  = ev_vec | ((wr_en_i && sel == SEL_CSET) ? wdata_i : '0);
   assign cause_rd = rd_en_i && (sel == SEL_CAUSE);

   irq_cause_reg #(.DATA_W(DATA_W), .VALID(VALID)) cause_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .rd_clr_i(cause_rd),
      .aclr_i  (aclr),
      .cause_o (cause)
   );

   irq_enable_reg #(.DATA_W(DATA_W), .VALID(VALID)) mask_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we_i (wr_en_i && sel == SEL_MSET),
      .clr_we_i (wr_en_i && sel == SEL_MCLR),
      .load_we_i(1'b0),
      .d_i      (wdata_i),
      .q_o      (mask)
   );

   irq_enable_reg #(.DATA_W(DATA_W), .VALID(VALID)) aclr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we_i (1'b0),
      .clr_we_i (1'b0),
      .load_we_i(wr_en_i && sel == SEL_ACLR),
      .d_i      (wdata_i),
      .q_o      (aclr)
   );

   irq_req_out #(.DATA_W(DATA_W), .REGISTERED(OUT_REG)) req_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cause_i(cause),
      .mask_i (mask),
      .irq_o  (irq_o)
   );

   always_comb begin
      unique case (sel)
         SEL_CAUSE: rdata_o = cause;
         SEL_MSET:  rdata_o = mask;
         SEL_ACLR:  rdata_o = aclr;
         default:   rdata_o = '0;
      endcase
   end

   // R9
   undefined_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause | mask | aclr) & ~VALID) == '0);

   // R2
   link_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_link_i |=> cause[LSC_BIT]);
endmodule

// File: tb/irq_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cause_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_rx = 1'b0, ev_tx = 1'b0, ev_link = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [13:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;

   localparam logic [13:0] A_CAUSE = 14'h200, A_CSET = 14'h202, A_ACLR = 14'h204,
                           A_MSET = 14'h220, A_MCLR = 14'h222;

   always #2.5 clk = ~clk;

   irq_cause_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ev_rx_i(ev_rx), .ev_tx_i(ev_tx), .ev_link_i(ev_link),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq)
   );

   // {rd, addr[14:0], data or expected, requirement number}
   localparam int NV = 17;
   localparam logic [79:0] VEC [NV] = '{
      {1'b0, 15'h204, 32'hFFFF_FFFF, 32'd9},
      {1'b1, 15'h204, 32'h0010_0003, 32'd9},   // R9 R7 auto-clear readable, defined bits only
      {1'b0, 15'h204, 32'h0000_0000, 32'd7},
      {1'b1, 15'h204, 32'h0000_0000, 32'd7},
      {1'b0, 15'h220, 32'hFFFF_FFFF, 32'd4},
      {1'b1, 15'h220, 32'h0010_0003, 32'd4},   // R4
      {1'b0, 15'h222, 32'h0000_0002, 32'd5},
      {1'b1, 15'h220, 32'h0010_0001, 32'd5},   // R5
      {1'b0, 15'h202, 32'h0000_0001, 32'd3},
      {1'b1, 15'h200, 32'h0000_0001, 32'd3},   // R3
      {1'b1, 15'h200, 32'h0000_0000, 32'd7},   // R7 zero auto-clear clears all
      {1'b0, 15'h202, 32'hFFFF_FFFF, 32'd3},
      {1'b1, 15'h200, 32'h0010_0003, 32'd3},
      {1'b1, 15'h200, 32'h0000_0000, 32'd7},
      {1'b1, 15'h100, 32'h0000_0000, 32'd9},   // R9 unmapped
      {1'b0, 15'h222, 32'hFFFF_FFFF, 32'd5},
      {1'b1, 15'h220, 32'h0000_0000, 32'd5}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   // returns value seen in the read cycle; side effect lands at the following edge
   task automatic rd(input logic [13:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      ev_rx = (which == 0); ev_tx = (which == 1); ev_link = (which == 2);
      @(negedge clk);
      ev_rx = 1'b0; ev_tx = 1'b0; ev_link = 1'b0;
   endtask

   initial begin
      #500000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd(A_CAUSE, v); check("R1 cause", v, 32'd0);
      rd(A_MSET, v);  check("R1 mask", v, 32'd0);
      rd(A_ACLR, v);  check("R1 aclr", v, 32'd0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][31:0], i);
         if (VEC[i][79]) begin
            rd(VEC[i][77:64], v);
            check(tag, v, VEC[i][63:32]);
         end else begin
            wr(VEC[i][77:64], VEC[i][63:32]);
         end
      end

      // R2 events, R6 irq timing
      wr(A_MSET, 32'h0010_0003);
      pulse(0);
      check("R6 irq not yet", {31'd0, irq}, 32'd0);
      @(negedge clk);
      check("R6 irq rise", {31'd0, irq}, 32'd1);
      rd(A_CAUSE, v); check("R2 rx bit0", v, 32'h1);
      check("R6 irq held one cycle", {31'd0, irq}, 32'd1);
      @(negedge clk);
      check("R6 irq fall", {31'd0, irq}, 32'd0);
      pulse(1);
      rd(A_CAUSE, v); check("R2 tx bit1", v, 32'h2);
      pulse(2);
      rd(A_CAUSE, v); check("R2 link bit20", v, 32'h0010_0000);

      // R7 partial auto-clear
      wr(A_ACLR, 32'h1);
      wr(A_CSET, 32'h3);
      rd(A_CAUSE, v); check("R7 partial first", v, 32'h3);
      rd(A_CAUSE, v); check("R7 partial kept", v, 32'h2);
      wr(A_ACLR, 32'h0);
      rd(A_CAUSE, v);

      // R8 event collides with clearing read
      wr(A_CSET, 32'h1);
      @(negedge clk);
      rd_en = 1'b1; addr = A_CAUSE; ev_link = 1'b1;
      #1 v = rdata;
      check("R8 read value", v, 32'h1);
      @(negedge clk);
      rd_en = 1'b0; ev_link = 1'b0;
      rd(A_CAUSE, v); check("R8 event wins", v, 32'h0010_0000);

      // R6 masked cause does not raise irq
      repeat (2) @(negedge clk);
      wr(A_MCLR, 32'hFFFF_FFFF);
      wr(A_CSET, 32'h1);
      repeat (2) @(negedge clk);
      check("R6 masked no irq", {31'd0, irq}, 32'd0);
      wr(A_MSET, 32'h1);
      check("R6 unmask not yet", {31'd0, irq}, 32'd0);
      @(negedge clk);
      check("R6 unmask rise", {31'd0, irq}, 32'd1);
      wr(A_MCLR, 32'h1);
      @(negedge clk);
      check("R5 R6 mask clear drops irq", {31'd0, irq}, 32'd0);
      rd(A_CAUSE, v); check("R6 cause still pending", v, 32'h1);

      // R9 write to cause address itself is ignored
      wr(A_CAUSE, 32'hFFFF_FFFF);
      rd(A_CAUSE, v); check("R9 cause addr write ignored", v, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule